// File: doc/BRIEF.md
# Misaligned Word Load Assembler

This block sits between a processor's load port and a data cache that can only return naturally aligned 32-bit words. The processor hands it a full byte address for a 32-bit load. The block checks the two lowest address bits. When they are zero it makes a single aligned word read. Otherwise it makes two aligned reads, one to the word that holds the first requested byte and one to the word after it. The two words may sit in different cache lines.

Each read is held until the cache answers with a data-valid pulse. The cache may answer after any number of cycles, so each read can stall on its own miss. When the data is in, the block uses the byte offset to pick the requested bytes out of the returned words and joins them into one little-endian 32-bit result. It presents that result together with a one-cycle completion pulse. Only one load is handled at a time.

Top module: `unaligned_load_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `ld_ready_o` is 1, and `ld_done_o` and `mem_req_o` are 0.
- R2: A load whose address has low bits 00 issues exactly one cache read, at word address `ld_addr_i[31:2]`, and returns that word unchanged.
- R3: A load whose low address bits are nonzero issues exactly two cache reads. The first is at word address `ld_addr_i[31:2]` and the second is at that word address plus one.
- R4: The second word address wraps from all ones to zero, so a load that starts in the last word of the address space reads word 0 second.
- R5: The result is little-endian. Byte i of `ld_data_o` (bits 8i+7..8i) equals the memory byte at byte address `ld_addr_i + i`, taken modulo 2^32. This holds for offsets 0, 1, 2 and 3, and for loads that cross a 128-byte line.
- R6: Once `mem_req_o` is raised, it stays high with `mem_addr_o` unchanged until a cycle in which `mem_dvalid_i` is 1. `mem_data_i` is sampled only in that cycle, whatever the response latency.
- R7: `ld_ready_o` is 0 from the cycle after a load is accepted up to and including its completion cycle. `ld_valid_i` and `ld_addr_i` are ignored during that time and do not change the result.
- R8: `ld_done_o` is high for exactly one cycle per load, with `ld_data_o` holding the result in that cycle. `mem_req_o` is 0 in that cycle, and `ld_ready_o` is 1 in the cycle after it.
- R9: The cache address port carries only the word address (`ADDR_W-2` bits). The two byte-offset bits never reach the cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid_i | input | 1 | Load request valid |
| ld_addr_i | input | ADDR_W (32) | Byte address of the 32-bit load |
| ld_ready_o | output | 1 | Block is idle and can accept a load |
| ld_data_o | output | DATA_W (32) | Reassembled load result |
| ld_done_o | output | 1 | One-cycle pulse: result valid |
| mem_req_o | output | 1 | Cache read request, held until answered |
| mem_addr_o | output | ADDR_W-2 (30) | Aligned word address to the cache |
| mem_data_i | input | DATA_W (32) | Word returned by the cache |
| mem_dvalid_i | input | 1 | Cache response valid |

## Verification
The bench sweeps all four byte offsets over several base addresses. These include a line-crossing word at 0x7C, a line start, and the last two words of the address space. Together they separate one-read loads from two-read loads, show whether the byte rotation is right for each offset, and show whether the word increment wraps. The memory model answers each read after a random delay of zero to four cycles, which exposes any capture that happens before the data is valid. Every other load keeps a conflicting request driven while the block is busy, which shows whether in-flight requests are ignored. Memory bytes are computed from their byte address, so each expected result is worked out directly from `addr+i`.

// File: rtl/ulu_pkg.sv
package ulu_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD0  = 2'd1,
      ST_RD1  = 2'd2,
      ST_DONE = 2'd3
   } ulu_state_e;

endpackage

// File: rtl/ulu_ctrl.sv
module ulu_ctrl #(
   parameter int WA_W   = 30,
   parameter int OFS_W  = 2,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid_i,
   input  logic [WA_W-1:0]   ld_waddr_i,
   input  logic [OFS_W-1:0]  ld_ofs_i,
   input  logic [DATA_W-1:0] mem_data_i,
   input  logic              mem_dvalid_i,
   output logic              ready_o,
   output logic              done_o,
   output logic              req_o,
   output logic [WA_W-1:0]   waddr_o,
   output logic [DATA_W-1:0] lo_word_o,
   output logic [DATA_W-1:0] hi_word_o,
   output logic [OFS_W-1:0]  ofs_o
);
   import ulu_pkg::*;

   ulu_state_e          state_q;
   logic [WA_W-1:0]     wa_q;
   logic [OFS_W-1:0]    ofs_q;
   logic [DATA_W-1:0]   lo_q;
   logic [DATA_W-1:0]   hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wa_q    <= '0;
         ofs_q   <= '0;
         lo_q    <= '0;
         hi_q    <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (ld_valid_i) begin
                  wa_q    <= ld_waddr_i;
                  ofs_q   <= ld_ofs_i;
                  state_q <= ST_RD0;
               end
            end
            ST_RD0: begin
               if (mem_dvalid_i) begin
                  lo_q    <= mem_data_i;
                  state_q <= (ofs_q == '0) ? ST_DONE : ST_RD1;
               end
            end
            ST_RD1: begin
               if (mem_dvalid_i) begin
                  hi_q    <= mem_data_i;
                  state_q <= ST_DONE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // Second word address: plain increment, wraps at the top of the space.
   always_comb begin
      ready_o   = (state_q == ST_IDLE);
      done_o    = (state_q == ST_DONE);
      req_o     = (state_q == ST_RD0) || (state_q == ST_RD1);
      waddr_o   = (state_q == ST_RD1) ? wa_q + 1'b1 : wa_q;
      lo_word_o = lo_q;
      hi_word_o = hi_q;
      ofs_o     = ofs_q;
   end

endmodule

// File: rtl/ulu_merge.sv
module ulu_merge #(
   parameter int NBYTES = 4,
   parameter int OFS_W  = 2
) (
   input  logic [NBYTES*8-1:0] lo_word_i,
   input  logic [NBYTES*8-1:0] hi_word_i,
   input  logic [OFS_W-1:0]    ofs_i,
   output logic [NBYTES*8-1:0] data_o
);
   localparam int CAT_W = 2 * NBYTES * 8;

   logic [CAT_W-1:0] cat;
   assign cat = {hi_word_i, lo_word_i};

   // Little-endian: output byte i comes from concatenated byte i+ofs.
   for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      always_comb begin
         data_o[i*8 +: 8] = cat[i*8 +: 8];
         for (int k = 0; k < NBYTES; k++) begin
            if (ofs_i == k[OFS_W-1:0]) data_o[i*8 +: 8] = cat[(i+k)*8 +: 8];
         end
      end
   end

endmodule

// File: rtl/unaligned_load_unit.sv
module unaligned_load_unit #(
   parameter  int ADDR_W = 32,
   parameter  int DATA_W = 32,
   localparam int NBYTES = DATA_W / 8,
   localparam int OFS_W  = $clog2(NBYTES),
   localparam int WA_W   = ADDR_W - OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid_i,
   input  logic [ADDR_W-1:0] ld_addr_i,
   output logic              ld_ready_o,
   output logic [DATA_W-1:0] ld_data_o,
   output logic              ld_done_o,
   output logic              mem_req_o,
   output logic [WA_W-1:0]   mem_addr_o,
   input  logic [DATA_W-1:0] mem_data_i,
   input  logic              mem_dvalid_i
);

   if ((DATA_W % 8) != 0 || NBYTES < 2 || (1 << OFS_W) != NBYTES) begin : g_bad_data_w
      $error("DATA_W must be a power-of-two number of bytes, at least two");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr_w
      $error("ADDR_W must exceed the byte-offset width");
   end

   logic [DATA_W-1:0] lo_word, hi_word;
   logic [OFS_W-1:0]  ofs;

   ulu_ctrl #(
      .WA_W   (WA_W),
      .OFS_W  (OFS_W),
      .DATA_W (DATA_W)
   ) ctrl_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .ld_valid_i   (ld_valid_i),
      .ld_waddr_i   (ld_addr_i[ADDR_W-1:OFS_W]),
      .ld_ofs_i     (ld_addr_i[OFS_W-1:0]),
      .mem_data_i   (mem_data_i),
      .mem_dvalid_i (mem_dvalid_i),
      .ready_o      (ld_ready_o),
      .done_o       (ld_done_o),
      .req_o        (mem_req_o),
      .waddr_o      (mem_addr_o),
      .lo_word_o    (lo_word),
      .hi_word_o    (hi_word),
      .ofs_o        (ofs)
   );

   ulu_merge #(
      .NBYTES (NBYTES),
      .OFS_W  (OFS_W)
   ) merge_i (
      .lo_word_i (lo_word),
      .hi_word_i (hi_word),
      .ofs_i     (ofs),
      .data_o    (ld_data_o)
   );

endmodule

// File: rtl/ulu_checker.sv
module ulu_checker #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic                                    clk,
   input logic                                    rst_n,
   input logic                                    ld_ready_o,
   input logic                                    ld_done_o,
   input logic                                    mem_req_o,
   input logic                                    mem_dvalid_i,
   input logic [ADDR_W-$clog2(DATA_W/8)-1:0]      mem_addr_o
);

   // R6: a pending read holds its request and address until answered
   a_r6_hold_until_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_dvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

   // R3, R4: a back-to-back second read targets the next word, wrapping
   a_r3_next_word: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_dvalid_i) |=> (!mem_req_o || mem_addr_o == $past(mem_addr_o) + 1'b1));

   // R8: completion is a single-cycle pulse with no read outstanding
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ld_done_o |=> !ld_done_o);
   a_r8_done_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      ld_done_o |-> !mem_req_o);
   a_r8_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      ld_done_o |=> ld_ready_o);

   // R7: not ready while a load is in flight
   a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o || ld_done_o) |-> !ld_ready_o);

endmodule

bind unaligned_load_unit ulu_checker #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .ld_ready_o   (ld_ready_o),
   .ld_done_o    (ld_done_o),
   .mem_req_o    (mem_req_o),
   .mem_dvalid_i (mem_dvalid_i),
   .mem_addr_o   (mem_addr_o)
);

// File: tb/unaligned_load_unit_tb_top.sv
module unaligned_load_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_valid = 1'b0;
   logic [31:0] ld_addr = '0;
   logic        ld_ready_o, ld_done_o, mem_req_o;
   logic [31:0] ld_data_o;
   logic [29:0] mem_addr_o;
   logic [31:0] mem_data = 32'hDEADBEEF;
   logic        mem_dvalid = 1'b0;

   int tests = 0;
   int fails = 0;
   int resp_cnt = 0;
   logic [29:0] resp_addr [4];
   int lat = 0;

   always #10 clk = ~clk;   // 50 MHz

   unaligned_load_unit dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .ld_valid_i   (ld_valid),
      .ld_addr_i    (ld_addr),
      .ld_ready_o   (ld_ready_o),
      .ld_data_o    (ld_data_o),
      .ld_done_o    (ld_done_o),
      .mem_req_o    (mem_req_o),
      .mem_addr_o   (mem_addr_o),
      .mem_data_i   (mem_data),
      .mem_dvalid_i (mem_dvalid)
   );

   function automatic logic [7:0] mem_byte(input logic [31:0] b);
      return (b[7:0] * 8'd13) ^ b[15:8] ^ b[31:24] ^ 8'h3C;
   endfunction

   function automatic logic [31:0] mem_word(input logic [29:0] w);
      return {mem_byte({w, 2'd3}), mem_byte({w, 2'd2}),
              mem_byte({w, 2'd1}), mem_byte({w, 2'd0})};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Cache model: random latency 0..4 cycles per read
   initial begin
      forever begin
         @(negedge clk);
         if (mem_dvalid) begin
            mem_dvalid = 1'b0;
            mem_data   = 32'hDEADBEEF;
            lat        = $urandom_range(0, 4);
         end else if (rst_n && mem_req_o) begin
            if (lat == 0) begin
               mem_dvalid = 1'b1;
               mem_data   = mem_word(mem_addr_o);
               if (resp_cnt < 4) resp_addr[resp_cnt] = mem_addr_o;
               resp_cnt++;
            end else begin
               lat--;
            end
         end
      end
   end

   task automatic do_load(input logic [31:0] a, input bit junk);
      int cyc;
      bit busy_ok;
      logic [31:0] exp;
      int exp_reads;
      @(negedge clk);
      while (!ld_ready_o) @(negedge clk);
      resp_cnt = 0;
      ld_valid = 1'b1;
      ld_addr  = a;
      @(negedge clk);
      if (junk) begin
         ld_valid = 1'b1;
         ld_addr  = ~a;
      end else begin
         ld_valid = 1'b0;
      end
      cyc = 0;
      busy_ok = 1'b1;
      while (!ld_done_o && cyc < 300) begin
         if (ld_ready_o) busy_ok = 1'b0;
         @(negedge clk);
         cyc++;
      end
      ld_valid = 1'b0;
      if (!ld_done_o) begin
         chk(1'b0, "R6 watchdog: load never completed", a, 32'h0);
         return;
      end
      if (ld_ready_o) busy_ok = 1'b0;
      for (int i = 0; i < 4; i++) exp[i*8 +: 8] = mem_byte(a + i);
      exp_reads = (a[1:0] == 2'd0) ? 1 : 2;
      chk(ld_data_o == exp, (a[1:0] == 2'd0) ? "R2/R6 aligned data" : "R5/R6 merged data",
          ld_data_o, exp);
      chk(resp_cnt == exp_reads, (exp_reads == 1) ? "R2 read count" : "R3 read count",
          resp_cnt, exp_reads);
      chk(resp_addr[0] == a[31:2], "R9 first word address", {2'b0, resp_addr[0]}, {2'b0, a[31:2]});
      if (exp_reads == 2 && resp_cnt >= 2)
         chk(resp_addr[1] == a[31:2] + 30'd1, (a[31:2] == 30'h3FFFFFFF) ? "R4 wrapped second address" : "R3 second address",
             {2'b0, resp_addr[1]}, {2'b0, a[31:2] + 30'd1});
      chk(busy_ok, junk ? "R7 busy ready low, extra request ignored" : "R7 busy ready low",
          {31'b0, busy_ok}, 32'd1);
      @(negedge clk);
      chk(!ld_done_o && ld_ready_o, "R8 single done pulse then ready",
          {30'b0, ld_done_o, ld_ready_o}, 32'd1);
   endtask

   initial begin
      logic [31:0] bases [8];
      bases[0] = 32'h0000_0000;
      bases[1] = 32'h0000_007C;
      bases[2] = 32'h0000_0078;
      bases[3] = 32'h0000_0080;
      bases[4] = 32'h0000_01FC;
      bases[5] = 32'h1234_5670;
      bases[6] = 32'hFFFF_FFF8;
      bases[7] = 32'hFFFF_FFFC;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(ld_ready_o && !ld_done_o && !mem_req_o, "R1 reset outputs",
          {29'b0, ld_ready_o, ld_done_o, mem_req_o}, 32'h4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ld_ready_o && !ld_done_o && !mem_req_o, "R1 first cycle after reset",
          {29'b0, ld_ready_o, ld_done_o, mem_req_o}, 32'h4);
      for (int b = 0; b < 8; b++) begin
         for (int o = 0; o < 4; o++) begin
            do_load(bases[b] + o, ((b + o) % 2) == 1);
         end
      end
      for (int n = 0; n < 40; n++) begin
         do_load($urandom, n[0]);
      end
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(20 * 150000);
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule